// File: doc/BRIEF.md
# Atomic Access Interlock Table with Deferred Release List

This block guards locked read-modify-write sequences issued by several cores. A locked load asks for exclusive ownership of an address. The block grants it when the address is free and a table slot is open. It denies the request when another core already holds that address. It reports "full" when every slot is taken. Each slot records the address and the core that owns it.

Releasing an interlock takes two steps. When the locked load (the read half of the atomic) commits, its address is appended to a short list of releasable addresses, and the interlock stays held. The interlocks named in that list are dropped only when the fence after the store half commits.

A misprediction annulment releases only the lock held by the annulled access. The list count is restored to the value it had when the annulment started, so locks queued by an atomic that is part-way through commit remain held. A full pipeline flush drops every interlock owned by the flushed core and empties the list.

Top module: `interlock_rmw_unit`

## Requirements
- R1: With `acq_valid` high and no live slot holding `acq_addr`, the block raises `acq_grant` in the same cycle, provided a free slot exists. From the next cycle on, the address is held by `acq_core`.
- R2: A request for an address held by a different core raises `acq_deny` instead of a grant. At most one of `acq_grant`, `acq_deny` and `acq_full` is high in any cycle, and none of them is high without `acq_valid`.
- R3: A request by a core for an address that the same core already holds is not granted, denied or reported full. Instead it sets `err_double`, which stays at 1 until reset.
- R4: A request for a free address while all LOCK_ENTRIES (default 8) slots are live raises `acq_full` and changes nothing.
- R5: `ld_commit_valid` appends `ld_commit_addr` to the release list, and `rel_count` rises by one on the next cycle. The interlock on that address stays held.
- R6: A fence commit (`fence_commit` with neither `annul_valid` nor `flush_valid`) releases every address in the list, and `rel_count` returns to 0.
- R7: An annulment with `annul_held_lock` releases only `annul_addr`. It leaves `rel_count` at the value sampled at the start of that cycle, and addresses already in the list stay held.
- R8: An annulment with `annul_held_lock` low releases nothing and leaves the list unchanged.
- R9: `flush_valid` releases every interlock owned by `flush_core` and sets `rel_count` to 0. A load commit in the same cycle is discarded. Interlocks held by other cores are kept.
- R10: A load commit while the list holds REL_DEPTH (default 4) addresses is dropped and sets `err_overflow`, which stays at 1 until reset. `rel_count` never exceeds REL_DEPTH.
- R11: When drain events coincide, the order is flush, then annulment, then fence. A fence that arrives in the same cycle as an annulment or a flush has no effect.
- R12: An acquire is judged after the releases of the same cycle. A request for an address released in that cycle is granted.
- R13: A load commit in the same cycle as a fence or annulment is appended after that drain. With a fence it becomes the only entry (count 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_valid | input | 1 | Locked-load acquire request |
| acq_addr | input | ADDR_W | Address to interlock |
| acq_core | input | CORE_W | Requesting core |
| acq_grant | output | 1 | Interlock granted this cycle |
| acq_deny | output | 1 | Held by another core; requester must stall |
| acq_full | output | 1 | No free slot |
| ld_commit_valid | input | 1 | Locked load committed |
| ld_commit_addr | input | ADDR_W | Address queued as releasable |
| fence_commit | input | 1 | Fence after the store half committed |
| annul_valid | input | 1 | Misprediction annulment of one access |
| annul_held_lock | input | 1 | Annulled access held an interlock |
| annul_addr | input | ADDR_W | Address of that interlock |
| flush_valid | input | 1 | Full pipeline flush |
| flush_core | input | CORE_W | Core being flushed |
| rel_count | output | $clog2(REL_DEPTH+1) | Entries in the release list |
| err_double | output | 1 | Sticky: same-core re-acquire |
| err_overflow | output | 1 | Sticky: push into a full list |

## Verification
Three kinds of event can land in the same cycle: a drain (fence, annulment or flush), a load commit that appends to the list, and an acquire that races a release. The bench drives a fence together with an annulment, and a flush together with an annulment and a load commit. In each case it checks that only the higher-priority drain takes effect. It also drives a fence together with an acquire of an address being freed, and a fence together with a new load commit. Every cycle, a behavioural model built from lists and keyed maps judges the grant, deny and full outputs, the list count and the error flags. Lock state is checked only through later acquire outcomes.

// File: rtl/interlock_pkg.sv
package interlock_pkg;

    // Which drain operation takes effect this cycle, after priority.
    typedef enum logic [1:0] {
        DRAIN_NONE  = 2'd0,
        DRAIN_FENCE = 2'd1,
        DRAIN_ANNUL = 2'd2,
        DRAIN_FLUSH = 2'd3
    } drain_e;

    // Outcome of an acquire request.
    typedef enum logic [2:0] {
        ACQ_IDLE   = 3'd0,
        ACQ_GRANT  = 3'd1,
        ACQ_DENY   = 3'd2,
        ACQ_FULL   = 3'd3,
        ACQ_DOUBLE = 3'd4
    } acq_res_e;

endpackage

// File: rtl/drain_arbiter.sv
module drain_arbiter
    import interlock_pkg::*;
(
    input  logic   flush_valid,
    input  logic   annul_valid,
    input  logic   fence_commit,
    output drain_e drain
);

    // Flush discards everything, annulment wins over fence (R11).
    always_comb begin
        if (flush_valid)       drain = DRAIN_FLUSH;
        else if (annul_valid)  drain = DRAIN_ANNUL;
        else if (fence_commit) drain = DRAIN_FENCE;
        else                   drain = DRAIN_NONE;
    end

endmodule

// File: rtl/release_queue.sv
module release_queue
    import interlock_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int DEPTH  = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  drain_e                       drain,
    input  logic                         push_valid,
    input  logic [ADDR_W-1:0]            push_addr,
    output logic [DEPTH-1:0][ADDR_W-1:0] q_addr,
    output logic [CNT_W-1:0]             q_count,
    output logic                         overflow_err
);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] slot;
        logic [CNT_W-1:0]             cnt;
        logic                         ovf;
    } rq_t;

    rq_t s_d, s_q;

    always_comb begin
        s_d = s_q;

        // Fence and flush empty the list. An annulment samples the count,
        // conceptually appends the annulled lock at that index, releases from
        // the sampled index onward and restores the count. The net effect on
        // the list is none, so entries of a half-committed atomic survive.
        case (drain)
            DRAIN_FLUSH, DRAIN_FENCE: s_d.cnt = '0;
            default: ;
        endcase

        // A load commit appends after the drain (R13). Under a flush it is lost.
        if (push_valid && (drain != DRAIN_FLUSH)) begin
            if (s_d.cnt == CNT_W'(DEPTH)) begin
                s_d.ovf = 1'b1;
            end else begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (CNT_W'(j) == s_d.cnt) s_d.slot[j] = push_addr;
                end
                s_d.cnt = s_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_addr       = s_q.slot;
    assign q_count      = s_q.cnt;
    assign overflow_err = s_q.ovf;

endmodule

// File: rtl/interlock_table.sv
module interlock_table
    import interlock_pkg::*;
#(
    parameter  int ADDR_W  = 32,
    parameter  int CORE_W  = 2,
    parameter  int ENTRIES = 8,
    parameter  int DEPTH   = 4,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  drain_e                       drain,
    input  logic [CORE_W-1:0]            flush_core,
    input  logic                         annul_held,
    input  logic [ADDR_W-1:0]            annul_addr,
    input  logic [DEPTH-1:0][ADDR_W-1:0] q_addr,
    input  logic [CNT_W-1:0]             q_count,
    input  logic                         acq_valid,
    input  logic [ADDR_W-1:0]            acq_addr,
    input  logic [CORE_W-1:0]            acq_core,
    output acq_res_e                     acq_result,
    output logic                         double_err
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [CORE_W-1:0] owner;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
        logic               dbl;
    } tbl_t;

    tbl_t s_d, s_q;

    logic [ENTRIES-1:0] rel;
    logic [ENTRIES-1:0] live;
    logic               hit_any;
    logic               hit_same;
    logic               free_any;
    logic [IDX_W-1:0]   free_idx;
    acq_res_e           res;

    always_comb begin
        s_d = s_q;

        // Release mask from start-of-cycle state.
        for (int i = 0; i < ENTRIES; i++) begin
            rel[i] = 1'b0;
            case (drain)
                DRAIN_FLUSH: rel[i] = (s_q.ent[i].owner == flush_core);
                DRAIN_ANNUL: rel[i] = annul_held && (s_q.ent[i].addr == annul_addr);
                DRAIN_FENCE: begin
                    for (int j = 0; j < DEPTH; j++) begin
                        if ((j < int'(q_count)) && (q_addr[j] == s_q.ent[i].addr)) rel[i] = 1'b1;
                    end
                end
                default: ;
            endcase
            rel[i]  = rel[i] & s_q.ent[i].valid;
            live[i] = s_q.ent[i].valid & ~rel[i];
        end

        // Acquire sees the table after this cycle's releases (R12).
        hit_any  = 1'b0;
        hit_same = 1'b0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (live[i] && (s_q.ent[i].addr == acq_addr)) begin
                hit_any  = 1'b1;
                hit_same = (s_q.ent[i].owner == acq_core);
            end
            if (!live[i] && !free_any) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end

        if (!acq_valid)     res = ACQ_IDLE;
        else if (hit_any)   res = hit_same ? ACQ_DOUBLE : ACQ_DENY;
        else if (!free_any) res = ACQ_FULL;
        else                res = ACQ_GRANT;

        for (int i = 0; i < ENTRIES; i++) s_d.ent[i].valid = live[i];

        if (res == ACQ_GRANT) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == free_idx) begin
                    s_d.ent[i].valid = 1'b1;
                    s_d.ent[i].addr  = acq_addr;
                    s_d.ent[i].owner = acq_core;
                end
            end
        end

        if (res == ACQ_DOUBLE) s_d.dbl = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acq_result = res;
    assign double_err = s_q.dbl;

endmodule

// File: rtl/interlock_rmw_unit.sv
module interlock_rmw_unit
    import interlock_pkg::*;
#(
    parameter  int ADDR_W       = 32,
    parameter  int CORE_W       = 2,
    parameter  int LOCK_ENTRIES = 8,
    parameter  int REL_DEPTH    = 4,
    localparam int CNT_W        = $clog2(REL_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_valid,
    input  logic [ADDR_W-1:0] acq_addr,
    input  logic [CORE_W-1:0] acq_core,
    output logic              acq_grant,
    output logic              acq_deny,
    output logic              acq_full,
    input  logic              ld_commit_valid,
    input  logic [ADDR_W-1:0] ld_commit_addr,
    input  logic              fence_commit,
    input  logic              annul_valid,
    input  logic              annul_held_lock,
    input  logic [ADDR_W-1:0] annul_addr,
    input  logic              flush_valid,
    input  logic [CORE_W-1:0] flush_core,
    output logic [CNT_W-1:0]  rel_count,
    output logic              err_double,
    output logic              err_overflow
);

    drain_e                           drain;
    logic [REL_DEPTH-1:0][ADDR_W-1:0] q_addr;
    logic [CNT_W-1:0]                 q_count;
    acq_res_e                         acq_result;

    drain_arbiter u_arb (
        .flush_valid  (flush_valid),
        .annul_valid  (annul_valid),
        .fence_commit (fence_commit),
        .drain        (drain)
    );

    release_queue #(
        .ADDR_W (ADDR_W),
        .DEPTH  (REL_DEPTH)
    ) u_rq (
        .clk          (clk),
        .rst_n        (rst_n),
        .drain        (drain),
        .push_valid   (ld_commit_valid),
        .push_addr    (ld_commit_addr),
        .q_addr       (q_addr),
        .q_count      (q_count),
        .overflow_err (err_overflow)
    );

    interlock_table #(
        .ADDR_W  (ADDR_W),
        .CORE_W  (CORE_W),
        .ENTRIES (LOCK_ENTRIES),
        .DEPTH   (REL_DEPTH)
    ) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .drain      (drain),
        .flush_core (flush_core),
        .annul_held (annul_held_lock),
        .annul_addr (annul_addr),
        .q_addr     (q_addr),
        .q_count    (q_count),
        .acq_valid  (acq_valid),
        .acq_addr   (acq_addr),
        .acq_core   (acq_core),
        .acq_result (acq_result),
        .double_err (err_double)
    );

    assign acq_grant = (acq_result == ACQ_GRANT);
    assign acq_deny  = (acq_result == ACQ_DENY);
    assign acq_full  = (acq_result == ACQ_FULL);
    assign rel_count = q_count;

endmodule

// File: rtl/interlock_rmw_checker.sv
module interlock_rmw_checker #(
    parameter int REL_DEPTH = 4,
    parameter int CNT_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acq_valid,
    input logic             acq_grant,
    input logic             acq_deny,
    input logic             acq_full,
    input logic             ld_commit_valid,
    input logic             fence_commit,
    input logic             annul_valid,
    input logic             flush_valid,
    input logic [CNT_W-1:0] rel_count,
    input logic             err_double,
    input logic             err_overflow
);

    assert_one_response_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acq_grant, acq_deny, acq_full}));

    assert_response_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_grant || acq_deny || acq_full) |-> acq_valid);

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rel_count <= CNT_W'(REL_DEPTH));

    assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |=> err_overflow);

    assert_double_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_double |=> err_double);

    assert_fence_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_commit && !annul_valid && !flush_valid) |=> (rel_count <= 1));

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (rel_count == '0));

    assert_annul_restores_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (annul_valid && !flush_valid && !ld_commit_valid) |=> (rel_count == $past(rel_count)));

endmodule

bind interlock_rmw_unit interlock_rmw_checker #(
    .REL_DEPTH (REL_DEPTH),
    .CNT_W     (CNT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .acq_valid       (acq_valid),
    .acq_grant       (acq_grant),
    .acq_deny        (acq_deny),
    .acq_full        (acq_full),
    .ld_commit_valid (ld_commit_valid),
    .fence_commit    (fence_commit),
    .annul_valid     (annul_valid),
    .flush_valid     (flush_valid),
    .rel_count       (rel_count),
    .err_double      (err_double),
    .err_overflow    (err_overflow)
);

// File: tb/interlock_rmw_unit_bench.sv
module interlock_rmw_unit_bench;

    localparam int AW = 32;
    localparam int CW = 2;
    localparam int NE = 8;
    localparam int ND = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acq_valid, ld_commit_valid, fence_commit;
    logic          annul_valid, annul_held_lock, flush_valid;
    logic [AW-1:0] acq_addr, ld_commit_addr, annul_addr;
    logic [CW-1:0] acq_core, flush_core;
    logic          acq_grant, acq_deny, acq_full, err_double, err_overflow;
    logic [2:0]    rel_count;

    int vectors = 0;
    int fails   = 0;

    // Reference model state
    int unsigned lk[int unsigned];
    int unsigned rq[$];
    bit          m_dbl = 0;
    bit          m_ovf = 0;

    always #5 clk = ~clk;

    interlock_rmw_unit #(
        .ADDR_W(AW), .CORE_W(CW), .LOCK_ENTRIES(NE), .REL_DEPTH(ND)
    ) u_interlock_rmw_unit (
        .clk(clk), .rst_n(rst_n),
        .acq_valid(acq_valid), .acq_addr(acq_addr), .acq_core(acq_core),
        .acq_grant(acq_grant), .acq_deny(acq_deny), .acq_full(acq_full),
        .ld_commit_valid(ld_commit_valid), .ld_commit_addr(ld_commit_addr),
        .fence_commit(fence_commit),
        .annul_valid(annul_valid), .annul_held_lock(annul_held_lock), .annul_addr(annul_addr),
        .flush_valid(flush_valid), .flush_core(flush_core),
        .rel_count(rel_count), .err_double(err_double), .err_overflow(err_overflow)
    );

    task automatic chk(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        acq_valid = 0; acq_addr = '0; acq_core = '0;
        ld_commit_valid = 0; ld_commit_addr = '0; fence_commit = 0;
        annul_valid = 0; annul_held_lock = 0; annul_addr = '0;
        flush_valid = 0; flush_core = '0;
    endtask

    // Inputs are set by the caller after a rising edge; judged 2 ns later.
    task automatic tick(string tag);
        int unsigned rel_keys[$];
        bit eg, ed, ef, ndbl;
        int c0;
        bit d0, o0;
        #2;
        c0 = rq.size(); d0 = m_dbl; o0 = m_ovf;
        eg = 0; ed = 0; ef = 0; ndbl = m_dbl;
        if (flush_valid) begin
            foreach (lk[k]) if (lk[k] == flush_core) rel_keys.push_back(k);
        end else if (annul_valid) begin
            if (annul_held_lock && lk.exists(annul_addr)) rel_keys.push_back(annul_addr);
        end else if (fence_commit) begin
            foreach (rq[j]) if (lk.exists(rq[j])) rel_keys.push_back(rq[j]);
        end
        foreach (rel_keys[k]) if (lk.exists(rel_keys[k])) lk.delete(rel_keys[k]);
        if (acq_valid) begin
            if (lk.exists(acq_addr)) begin
                if (lk[acq_addr] == acq_core) ndbl = 1; else ed = 1;
            end else if (lk.num() >= NE) ef = 1;
            else begin eg = 1; lk[acq_addr] = acq_core; end
        end
        if (flush_valid || (fence_commit && !annul_valid)) rq.delete();
        if (ld_commit_valid && !flush_valid) begin
            if (rq.size() == ND) m_ovf = 1; else rq.push_back(ld_commit_addr);
        end
        m_dbl = ndbl;
        chk(tag, "acq_grant", int'(acq_grant), int'(eg));
        chk(tag, "acq_deny",  int'(acq_deny),  int'(ed));
        chk(tag, "acq_full",  int'(acq_full),  int'(ef));
        chk(tag, "rel_count", int'(rel_count), c0);
        chk(tag, "err_double", int'(err_double), int'(d0));
        chk(tag, "err_overflow", int'(err_overflow), int'(o0));
        @(posedge clk); #1;
    endtask

    task automatic acq(int unsigned a, int c, string tag);
        idle(); acq_valid = 1; acq_addr = a; acq_core = CW'(c); tick(tag);
    endtask

    task automatic commit_ld(int unsigned a, string tag);
        idle(); ld_commit_valid = 1; ld_commit_addr = a; tick(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick("R1");                                // reset state
        acq(32'h100, 0, "R1");                     // grant
        acq(32'h100, 1, "R2");                     // other core denied
        acq(32'h100, 0, "R3");                     // same-core re-acquire
        tick("R3");                                // sticky flag visible
        for (int i = 0; i < 7; i++) acq(32'h200 + 4 * i, 0, "R1");
        acq(32'h300, 2, "R4");                     // table full
        commit_ld(32'h100, "R5");                  // queued, still held
        acq(32'h100, 1, "R5");
        commit_ld(32'h200, "R5");
        // annul of a later access holding 0x204; 0x100/0x200 stay queued
        idle(); annul_valid = 1; annul_held_lock = 1; annul_addr = 32'h204; tick("R7");
        acq(32'h100, 1, "R7");                     // half-committed atomic kept
        acq(32'h204, 1, "R7");                     // annulled lock freed
        idle(); annul_valid = 1; annul_held_lock = 0; annul_addr = 32'h208; tick("R8");
        acq(32'h208, 1, "R8");                     // still held
        // fence drains list while core 1 grabs 0x100 in the same cycle
        idle(); fence_commit = 1; acq_valid = 1; acq_addr = 32'h100; acq_core = 1; tick("R12");
        acq(32'h200, 1, "R6");
        commit_ld(32'h208, "R5");
        idle(); fence_commit = 1; annul_valid = 1; tick("R11");
        acq(32'h208, 1, "R11");                    // fence ignored, still held
        idle(); fence_commit = 1; ld_commit_valid = 1; ld_commit_addr = 32'h20C; tick("R13");
        acq(32'h208, 1, "R13");                    // drained by that fence
        commit_ld(32'h210, "R10");
        commit_ld(32'h214, "R10");
        commit_ld(32'h218, "R10");
        commit_ld(32'h21C, "R10");                 // list full -> overflow
        tick("R10");
        // flush core 0 with annulment and load commit in the same cycle
        idle(); flush_valid = 1; flush_core = 0; annul_valid = 1; annul_held_lock = 1;
        annul_addr = 32'h100; ld_commit_valid = 1; ld_commit_addr = 32'h100; tick("R9");
        tick("R9");
        acq(32'h218, 1, "R9");                     // core 0 lock gone
        acq(32'h100, 2, "R9");                     // core 1 lock kept
        acq(32'h300, 3, "R4");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule